// File: doc/BRIEF.md
# Sound mode control decoder

This block turns a three-line mode control word and two identification flags into the control values for the sound path of a TV or VCR stereo decoder. The outputs are one select code for each of the two audio outputs, a mute enable, a request to clear the identification integrators, and drives for a stereo indicator and a dual-language indicator. An analog switch matrix downstream uses the select codes to pick among the mono, AM, left, right, L+R sum, dual A, dual B and external sources, or to mute.

The control lines arrive from slow external logic and may carry spikes. Each line goes through a two-flop synchronizer and then a counter filter. A new level is accepted only after it has been stable for a set number of clocks. The identification flags are synchronous to the block clock. After reset, the outputs stay muted for a hold period of about 1 ms, and only then does the filtered control word take effect. All outputs come from a single register stage, so a change of mode moves every select code in the same clock.

Top module: `snd_mode_ctl`

## Requirements
- R1: Select code values are mute 0, mono 1, AM 2, left 3, right 4, sum 5, A 6, B 7, external 8, and no other value ever appears. For HOLD_CYCLES clocks after reset is released, both selects are mute 0, mute_en and integ_clr are 1 and both LEDs are off, whatever the inputs are.
- R2: With ctrl_in[2:0] = 000, both selects are mute (0), integ_clr is 1 and both LEDs are off.
- R3: With ctrl_in = 100, both selects are mute (0), integ_clr is 0 and the LEDs show the identification status.
- R4: With ctrl_in = 001, the selects are left/right (3/4) when stereo is identified, A/B (6/7) when dual is identified, and mono/mono (1/1) otherwise.
- R5: With ctrl_in = 010, both selects are sum (5) in stereo, A (6) in dual, and mono (1) otherwise.
- R6: With ctrl_in = 011, both selects are sum (5) in stereo, B (7) in dual, and AM (2) otherwise.
- R7: With ctrl_in = 101, both selects are external (8) and the LEDs show the identification status. With ctrl_in = 110, both selects are external (8) and both LEDs are off.
- R8: With ctrl_in = 111, the code is illegal. Both selects are mute (0), both LEDs are off and integ_clr is 0.
- R9: In the modes that show identification status, led_stereo equals stereo_id and led_dual equals dual_id, each delayed by one clock. When both flags are set, the routing treats the transmission as stereo.
- R10: A level change on any control line that lasts fewer than FILT_CYCLES clocks has no effect on the outputs. A level that is held for longer takes effect within FILT_CYCLES+4 clocks.
- R11: mute_en is 1 exactly when both selects are mute (0). integ_clr is 1 only while mute_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_in | input | 3 | Mode control lines, bit 2 first, asynchronous |
| stereo_id | input | 1 | Stereo transmission identified |
| dual_id | input | 1 | Dual transmission identified |
| sel_out1 | output | 4 | Source select code for output 1 |
| sel_out2 | output | 4 | Source select code for output 2 |
| mute_en | output | 1 | Both outputs muted |
| integ_clr | output | 1 | Clear request for the identification integrators |
| led_stereo | output | 1 | Stereo indicator drive |
| led_dual | output | 1 | Dual indicator drive |

## Verification
Every one of the eight control codes is applied with each of the four flag combinations: none, stereo only, dual only, and both. This shows that routing depends on the identified transmission type, that stereo takes priority over dual, and which codes force the LEDs off. The hold window is sampled before it ends and again after it ends, to separate power-up muting from muting by code 000. A two-clock spike on one control line is checked cycle by cycle for no effect, and is followed by a held change of the same line that must take effect. This tells filtering apart from a line that is stuck or ignored.

// File: rtl/snd_mode_ctl_pkg.sv
package snd_mode_ctl_pkg;

    typedef enum logic [3:0] {
        SRC_MUTE  = 4'd0,
        SRC_MONO  = 4'd1,
        SRC_AM    = 4'd2,
        SRC_LEFT  = 4'd3,
        SRC_RIGHT = 4'd4,
        SRC_SUM   = 4'd5,
        SRC_CHA   = 4'd6,
        SRC_CHB   = 4'd7,
        SRC_EXT   = 4'd8
    } src_sel_t;

    typedef enum logic [1:0] {
        TX_MONO   = 2'd0,
        TX_STEREO = 2'd1,
        TX_DUAL   = 2'd2
    } tx_kind_t;

    typedef struct packed {
        src_sel_t sel1;
        src_sel_t sel2;
        logic     mute;
        logic     clr;
        logic     led_st;
        logic     led_du;
    } mode_word_t;

    localparam int CTRL_W = 3;

    // Stereo wins when both flags are present
    function automatic tx_kind_t classify_tx(input logic st, input logic du);
        if (st)      return TX_STEREO;
        else if (du) return TX_DUAL;
        else         return TX_MONO;
    endfunction

    function automatic mode_word_t muted_word(input logic clr);
        mode_word_t w;
        w.sel1   = SRC_MUTE;
        w.sel2   = SRC_MUTE;
        w.mute   = 1'b1;
        w.clr    = clr;
        w.led_st = 1'b0;
        w.led_du = 1'b0;
        return w;
    endfunction

    function automatic mode_word_t decode_mode(input logic [CTRL_W-1:0] code,
                                               input logic st, input logic du);
        mode_word_t w;
        tx_kind_t   k;
        logic       show_led;
        k        = classify_tx(st, du);
        w        = muted_word(1'b0);
        show_led = 1'b1;
        case (code)
            3'b000: begin
                w        = muted_word(1'b1);
                show_led = 1'b0;
            end
            3'b100: begin
                w        = muted_word(1'b0);
                show_led = 1'b1;
            end
            3'b001: begin
                case (k)
                    TX_STEREO: begin w.sel1 = SRC_LEFT; w.sel2 = SRC_RIGHT; end
                    TX_DUAL:   begin w.sel1 = SRC_CHA;  w.sel2 = SRC_CHB;   end
                    default:   begin w.sel1 = SRC_MONO; w.sel2 = SRC_MONO;  end
                endcase
            end
            3'b010: begin
                case (k)
                    TX_STEREO: begin w.sel1 = SRC_SUM;  w.sel2 = SRC_SUM;  end
                    TX_DUAL:   begin w.sel1 = SRC_CHA;  w.sel2 = SRC_CHA;  end
                    default:   begin w.sel1 = SRC_MONO; w.sel2 = SRC_MONO; end
                endcase
            end
            3'b011: begin
                case (k)
                    TX_STEREO: begin w.sel1 = SRC_SUM; w.sel2 = SRC_SUM; end
                    TX_DUAL:   begin w.sel1 = SRC_CHB; w.sel2 = SRC_CHB; end
                    default:   begin w.sel1 = SRC_AM;  w.sel2 = SRC_AM;  end
                endcase
            end
            3'b101: begin
                w.sel1 = SRC_EXT;
                w.sel2 = SRC_EXT;
            end
            3'b110: begin
                w.sel1   = SRC_EXT;
                w.sel2   = SRC_EXT;
                show_led = 1'b0;
            end
            default: begin
                w        = muted_word(1'b0);
                show_led = 1'b0;
            end
        endcase
        w.mute   = (w.sel1 == SRC_MUTE) && (w.sel2 == SRC_MUTE);
        w.led_st = show_led & st;
        w.led_du = show_led & du;
        return w;
    endfunction

endpackage

// File: rtl/snd_line_filter.sv
module snd_line_filter #(
    parameter int STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = (STABLE_CYCLES < 2) ? 1 : $clog2(STABLE_CYCLES + 1);

    logic sync1, sync2;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= din;
            sync2 <= sync1;
        end
    end

    generate
        if (STABLE_CYCLES < 2) begin : g_direct
            always_ff @(posedge clk) begin
                if (rst) dout <= 1'b0;
                else     dout <= sync2;
            end
        end else begin : g_count
            logic [CW-1:0] run_cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    dout    <= 1'b0;
                    run_cnt <= '0;
                end else if (sync2 == dout) begin
                    run_cnt <= '0;
                end else if (run_cnt == CW'(STABLE_CYCLES - 1)) begin
                    dout    <= sync2;
                    run_cnt <= '0;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/snd_powerup_hold.sv
module snd_powerup_hold #(
    parameter int HOLD_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst,
    output logic hold_done
);
    localparam int HW = $clog2(HOLD_CYCLES + 1);

    logic [HW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst)                               hold_cnt <= '0;
        else if (hold_cnt != HW'(HOLD_CYCLES)) hold_cnt <= hold_cnt + 1'b1;
    end

    assign hold_done = (hold_cnt == HW'(HOLD_CYCLES));

endmodule

// File: rtl/snd_route_decode.sv
module snd_route_decode
    import snd_mode_ctl_pkg::*;
(
    input  logic [CTRL_W-1:0] code,
    input  logic              stereo_id,
    input  logic              dual_id,
    input  logic              hold_done,
    output mode_word_t        word
);
    always_comb begin
        if (!hold_done) word = muted_word(1'b1);
        else            word = decode_mode(code, stereo_id, dual_id);
    end

endmodule

// File: rtl/snd_mode_ctl.sv
module snd_mode_ctl
    import snd_mode_ctl_pkg::*;
#(
    parameter int FILT_CYCLES = 4,
    parameter int HOLD_CYCLES = 50000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] ctrl_in,
    input  logic       stereo_id,
    input  logic       dual_id,
    output logic [3:0] sel_out1,
    output logic [3:0] sel_out2,
    output logic       mute_en,
    output logic       integ_clr,
    output logic       led_stereo,
    output logic       led_dual
);
    logic [CTRL_W-1:0] code_f;
    logic              hold_done;
    mode_word_t        next_word;
    mode_word_t        out_q;

    genvar gi;
    generate
        for (gi = 0; gi < CTRL_W; gi++) begin : g_line
            snd_line_filter #(.STABLE_CYCLES(FILT_CYCLES)) u_filt (
                .clk  (clk),
                .rst  (rst),
                .din  (ctrl_in[gi]),
                .dout (code_f[gi])
            );
        end
    endgenerate

    snd_powerup_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .hold_done (hold_done)
    );

    snd_route_decode u_dec (
        .code      (code_f),
        .stereo_id (stereo_id),
        .dual_id   (dual_id),
        .hold_done (hold_done),
        .word      (next_word)
    );

    always_ff @(posedge clk) begin
        if (rst) out_q <= muted_word(1'b1);
        else     out_q <= next_word;
    end

    assign sel_out1   = out_q.sel1;
    assign sel_out2   = out_q.sel2;
    assign mute_en    = out_q.mute;
    assign integ_clr  = out_q.clr;
    assign led_stereo = out_q.led_st;
    assign led_dual   = out_q.led_du;

endmodule

// File: rtl/snd_mode_ctl_chk.sv
module snd_mode_ctl_chk #(
    parameter int HOLD_CYCLES = 50000
) (
    input logic       clk,
    input logic       rst,
    input logic       stereo_id,
    input logic       dual_id,
    input logic [3:0] sel_out1,
    input logic [3:0] sel_out2,
    input logic       mute_en,
    input logic       integ_clr,
    input logic       led_stereo,
    input logic       led_dual
);
    localparam int HW = $clog2(HOLD_CYCLES + 1);

    logic [HW-1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                                since_rst <= '0;
        else if (since_rst != HW'(HOLD_CYCLES)) since_rst <= since_rst + 1'b1;
    end

    AST_HOLD_MUTE: assert property (@(posedge clk) disable iff (rst)
        (since_rst < HW'(HOLD_CYCLES)) |-> (mute_en && integ_clr && !led_stereo && !led_dual)); // R1

    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (rst)
        (sel_out1 <= 4'd8) && (sel_out2 <= 4'd8)); // R1

    AST_MUTE_FLAG: assert property (@(posedge clk) disable iff (rst)
        mute_en == ((sel_out1 == 4'd0) && (sel_out2 == 4'd0))); // R11

    AST_CLR_MUTED: assert property (@(posedge clk) disable iff (rst)
        integ_clr |-> mute_en); // R2

    AST_LED_ST_ID: assert property (@(posedge clk) disable iff (rst)
        led_stereo |-> $past(stereo_id)); // R9

    AST_LED_DU_ID: assert property (@(posedge clk) disable iff (rst)
        led_dual |-> $past(dual_id)); // R9

    AST_EXT_PAIR: assert property (@(posedge clk) disable iff (rst)
        (sel_out1 == 4'd8) |-> (sel_out2 == 4'd8)); // R7

    AST_LR_STEREO: assert property (@(posedge clk) disable iff (rst)
        (sel_out1 == 4'd3) |-> (sel_out2 == 4'd4 && $past(stereo_id))); // R4

endmodule

bind snd_mode_ctl snd_mode_ctl_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stereo_id  (stereo_id),
    .dual_id    (dual_id),
    .sel_out1   (sel_out1),
    .sel_out2   (sel_out2),
    .mute_en    (mute_en),
    .integ_clr  (integ_clr),
    .led_stereo (led_stereo),
    .led_dual   (led_dual)
);

// File: tb/snd_mode_ctl_test.sv
module snd_mode_ctl_test;
    localparam int FILT = 4;
    localparam int HOLD = 200;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] ctrl_in;
    logic       stereo_id, dual_id;
    logic [3:0] sel_out1, sel_out2;
    logic       mute_en, integ_clr, led_stereo, led_dual;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    snd_mode_ctl #(.FILT_CYCLES(FILT), .HOLD_CYCLES(HOLD)) uut (
        .clk(clk), .rst(rst), .ctrl_in(ctrl_in),
        .stereo_id(stereo_id), .dual_id(dual_id),
        .sel_out1(sel_out1), .sel_out2(sel_out2), .mute_en(mute_en),
        .integ_clr(integ_clr), .led_stereo(led_stereo), .led_dual(led_dual)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        finish_run();
    end

    task automatic check_out(string tag, logic [3:0] e1, logic [3:0] e2,
                             logic em, logic ec, logic els, logic eld);
        checks++;
        if (sel_out1 !== e1 || sel_out2 !== e2 || mute_en !== em ||
            integ_clr !== ec || led_stereo !== els || led_dual !== eld) begin
            failures++;
            $display("FAIL %s: actual sel=%0d/%0d mute=%b clr=%b led=%b%b expected sel=%0d/%0d mute=%b clr=%b led=%b%b",
                     tag, sel_out1, sel_out2, mute_en, integ_clr, led_stereo, led_dual,
                     e1, e2, em, ec, els, eld);
        end
    endtask

    task automatic expect_for(input logic [2:0] c, input logic st, input logic du,
                              output string tag, output logic [3:0] e1, output logic [3:0] e2,
                              output logic ec, output logic els, output logic eld);
        logic show;
        show = 1'b1; ec = 1'b0; e1 = 4'd0; e2 = 4'd0;
        case (c)
            3'b000: begin tag = "R2"; ec = 1'b1; show = 1'b0; end
            3'b100: begin tag = "R3"; end
            3'b001: begin tag = "R4";
                if (st)      begin e1 = 4'd3; e2 = 4'd4; end
                else if (du) begin e1 = 4'd6; e2 = 4'd7; end
                else         begin e1 = 4'd1; e2 = 4'd1; end
            end
            3'b010: begin tag = "R5";
                if (st)      begin e1 = 4'd5; e2 = 4'd5; end
                else if (du) begin e1 = 4'd6; e2 = 4'd6; end
                else         begin e1 = 4'd1; e2 = 4'd1; end
            end
            3'b011: begin tag = "R6";
                if (st)      begin e1 = 4'd5; e2 = 4'd5; end
                else if (du) begin e1 = 4'd7; e2 = 4'd7; end
                else         begin e1 = 4'd2; e2 = 4'd2; end
            end
            3'b101: begin tag = "R7"; e1 = 4'd8; e2 = 4'd8; end
            3'b110: begin tag = "R7"; e1 = 4'd8; e2 = 4'd8; show = 1'b0; end
            default: begin tag = "R8"; show = 1'b0; end
        endcase
        els = show & st;
        eld = show & du;
    endtask

    task automatic apply_mode(input logic [2:0] c, input logic st, input logic du);
        @(negedge clk);
        ctrl_in = c; stereo_id = st; dual_id = du;
        repeat (FILT + 8) @(negedge clk);
    endtask

    task automatic test_reset_hold();
        @(negedge clk);
        rst = 1'b1; ctrl_in = 3'b001; stereo_id = 1'b1; dual_id = 1'b0;
        repeat (3) @(negedge clk);
        check_out("R1 in reset", 4'd0, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        rst = 1'b0;
        repeat (HOLD / 2) @(negedge clk);
        check_out("R1 during hold", 4'd0, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        repeat (HOLD / 2 + 5) @(negedge clk);
        check_out("R1 after hold (R4)", 4'd3, 4'd4, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic test_all_modes();
        string tg;
        logic [3:0] e1, e2;
        logic ec, els, eld;
        for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 4; f++) begin
                apply_mode(3'(c), f[0], f[1]);
                expect_for(3'(c), f[0], f[1], tg, e1, e2, ec, els, eld);
                check_out($sformatf("%s/R9/R11 code=%0d st=%0d du=%0d", tg, c, f[0], f[1]),
                          e1, e2, (e1 == 4'd0 && e2 == 4'd0), ec, els, eld);
            end
        end
    endtask

    task automatic test_led_follow();
        apply_mode(3'b101, 1'b0, 1'b0);
        @(negedge clk);
        dual_id = 1'b1;
        @(negedge clk);
        check_out("R9 dual LED follows flag", 4'd8, 4'd8, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic test_spike();
        bit bad;
        apply_mode(3'b001, 1'b0, 1'b0);
        ctrl_in = 3'b011;
        repeat (2) @(negedge clk);
        ctrl_in = 3'b001;
        bad = 0;
        for (int i = 0; i < FILT + 8; i++) begin
            if (sel_out1 !== 4'd1 || sel_out2 !== 4'd1) bad = 1;
            @(negedge clk);
        end
        checks++;
        if (bad) begin
            failures++;
            $display("FAIL R10 spike: actual sel=%0d/%0d seen changed expected 1/1 throughout",
                     sel_out1, sel_out2);
        end
        ctrl_in = 3'b011;
        repeat (FILT + 4) @(negedge clk);
        check_out("R10 held change", 4'd2, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        rst = 1'b1; ctrl_in = 3'b000; stereo_id = 1'b0; dual_id = 1'b0;
        test_reset_hold();
        test_all_modes();
        test_led_follow();
        test_spike();
        finish_run();
    end

endmodule